// File: doc/BRIEF.md
# Comma Marker Detector for Latency Timestamping

This block monitors a parallel 10-bit line-code symbol stream for one special control character, K28.1. That character decodes to byte value 0x3C. After a link has finished aligning, the transmitter sends the character exactly once. When the detector sees it, the detector raises a marker output that can be routed to a test pin. External measurement equipment then uses the marker edge as a time reference for latency measurements. Full line decoding, serialisation and word alignment belong to other blocks.

The detector arms when the alignment-done input rises. It accepts the first matching symbol in either running-disparity form and ignores every later match until it is armed again. The accepted match produces a marker pulse whose length is set in symbol clocks, so the pulse can be made wide enough for a slow capture instrument. A sticky flag records that the character has been seen. The flag clears on reset or on the next arming edge. An optional registered comparison stage, chosen by a parameter, trades one cycle of latency for a shorter compare path.

Top module: `comma_marker_det`

## Requirements
- R1: After reset, `marker_o` and `seen_o` are both low.
- R2: The symbol 10'b0011111001 (`sym_i[9]` is the leftmost written bit) is recognised as the target character when `sym_vld_i` is high.
- R3: The symbol 10'b1100000110 (the opposite-disparity form, same bit order) is also recognised as the target character when `sym_vld_i` is high.
- R4: No other 10-bit value is recognised, including values one bit away from either form. A matching symbol with `sym_vld_i` low is ignored.
- R5: The detector arms on the clock edge at which `align_done_i` is sampled high after having been low at the previous edge. Detection is possible from the following edge onward. Matches before arming are ignored. `align_done_i` going low disarms the detector without clearing `seen_o`.
- R6: Only the first accepted match after an arming takes effect. Later matches leave `marker_o` and `seen_o` unchanged until the next arming.
- R7: With the default parameters, `marker_o` goes high on the edge that samples the accepted symbol. It stays high for `pulse_len_i` clock cycles, with `pulse_len_i` sampled on that edge, and then returns low. A length of 0 gives one cycle.
- R8: `seen_o` rises on the same edge as the marker. It stays high until reset or the next arming edge, which clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_i | input | SYM_W (10) | Parallel line-code symbol |
| sym_vld_i | input | 1 | Symbol qualifier |
| align_done_i | input | 1 | Link alignment complete; a rising edge arms the detector |
| pulse_len_i | input | LEN_W | Marker width in clock cycles (0 is treated as 1) |
| marker_o | output | 1 | One-shot timing marker |
| seen_o | output | 1 | Sticky flag: character detected since the last arming |

## Verification
With the default combinational compare, both results of an accepted symbol are due one edge after it is driven: `marker_o` and `seen_o` are both visible after the edge that samples the symbol. The marker then falls exactly `max(pulse_len_i,1)` edges later. An arming edge clears `seen_o` by that same edge, and a symbol can be accepted no earlier than the edge after arming. The bench drives inputs on the falling edge. A bench model advances by one state per rising edge, and the bench compares both outputs against that model at the next falling edge, so every check lands in the cycle the result is due.

// File: rtl/comma_pkg.sv
package comma_pkg;

   localparam int unsigned SYM_BITS = 10;
   localparam int unsigned NUM_PAT  = 2;

   // target character, both running-disparity forms
   function automatic logic [SYM_BITS-1:0] get_pattern(input int unsigned idx);
      return (idx == 0) ? 10'b0011111001 : 10'b1100000110;
   endfunction

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_DONE  = 2'd2
   } arm_state_t;

endpackage

// File: rtl/comma_match.sv
module comma_match #(
   parameter int unsigned SYM_W     = 10,
   parameter bit          REG_MATCH = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SYM_W-1:0] sym_i,
   input  logic             vld_i,
   output logic             hit_o
);
   import comma_pkg::*;

   if (SYM_W != SYM_BITS) begin : g_bad_width
      $error("comma_match: SYM_W must equal the symbol width of the line code");
   end

   logic [NUM_PAT-1:0] eq_vec;
   logic               any_eq;
   logic               vld_eff;

   for (genvar p = 0; p < NUM_PAT; p++) begin : g_cmp
      assign eq_vec[p] = (sym_i == get_pattern(p));
   end

   assign any_eq = |eq_vec;

   if (REG_MATCH) begin : g_reg
      logic hit_q;
      logic vld_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hit_q <= 1'b0;
            vld_q <= 1'b0;
         end else begin
            hit_q <= vld_i & any_eq;
            vld_q <= vld_i;
         end
      end
      assign hit_o   = hit_q;
      assign vld_eff = vld_q;
   end else begin : g_comb
      assign hit_o   = vld_i & any_eq;
      assign vld_eff = vld_i;
   end

   // R4
   only_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> vld_eff);

endmodule

// File: rtl/comma_arm_ctrl.sv
module comma_arm_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic align_i,
   input  logic hit_i,
   output logic detect_o,
   output logic seen_o
);
   import comma_pkg::*;

   arm_state_t state_q, state_d;
   logic       align_q;
   logic       arm_evt;

   assign arm_evt  = align_i & ~align_q;
   assign detect_o = (state_q == ST_ARMED) & align_i & hit_i & ~arm_evt;
   assign seen_o   = (state_q == ST_DONE);

   always_comb begin
      state_d = state_q;
      if (arm_evt) begin
         state_d = ST_ARMED;
      end else begin
         case (state_q)
            ST_ARMED: begin
               if (detect_o)      state_d = ST_DONE;
               else if (!align_i) state_d = ST_IDLE;
            end
            ST_DONE:  state_d = ST_DONE;
            default:  state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         align_q <= 1'b0;
      end else begin
         state_q <= state_d;
         align_q <= align_i;
      end
   end

   // R6
   one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      detect_o |=> (state_q != ST_ARMED));

   // R5
   arm_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm_evt |=> !seen_o);

   // R8
   seen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_o && !arm_evt) |=> seen_o);

endmodule

// File: rtl/comma_pulse_gen.sv
module comma_pulse_gen #(
   parameter int unsigned LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             marker_o
);

   if (LEN_W < 1 || LEN_W > 31) begin : g_bad_len
      $error("comma_pulse_gen: LEN_W out of range");
   end

   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] load_val;

   assign load_val = (len_i == '0) ? ONE : len_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   assign marker_o = (cnt_q != '0);

   // R7
   cnt_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - ONE));

   // R7
   load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> marker_o);

endmodule

// File: rtl/comma_marker_det.sv
module comma_marker_det #(
   parameter int unsigned SYM_W     = 10,
   parameter int unsigned LEN_W     = 4,
   parameter bit          REG_MATCH = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SYM_W-1:0] sym_i,
   input  logic             sym_vld_i,
   input  logic             align_done_i,
   input  logic [LEN_W-1:0] pulse_len_i,
   output logic             marker_o,
   output logic             seen_o
);

   logic hit;
   logic detect;

   comma_match #(.SYM_W(SYM_W), .REG_MATCH(REG_MATCH)) u_match (
      .clk   (clk),
      .rst_n (rst_n),
      .sym_i (sym_i),
      .vld_i (sym_vld_i),
      .hit_o (hit)
   );

   comma_arm_ctrl u_arm (
      .clk      (clk),
      .rst_n    (rst_n),
      .align_i  (align_done_i),
      .hit_i    (hit),
      .detect_o (detect),
      .seen_o   (seen_o)
   );

   comma_pulse_gen #(.LEN_W(LEN_W)) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (detect),
      .len_i    (pulse_len_i),
      .marker_o (marker_o)
   );

   // R8
   marker_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(marker_o) |-> $rose(seen_o));

endmodule

// File: tb/comma_marker_det_test.sv
module comma_marker_det_test;
   localparam int CLK_P = 10;
   localparam int LEN_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [9:0]       sym = '0;
   logic             vld = 1'b0;
   logic             aln = 1'b0;
   logic [LEN_W-1:0] len = '0;
   logic             marker, seen;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   // model state
   bit m_alq, m_arm, m_seen;
   int m_cnt;

   comma_marker_det #(.SYM_W(10), .LEN_W(LEN_W)) uut (
      .clk(clk), .rst_n(rst_n), .sym_i(sym), .sym_vld_i(vld),
      .align_done_i(aln), .pulse_len_i(len), .marker_o(marker), .seen_o(seen));

   always #(CLK_P/2) clk = ~clk;

   function automatic bit is_comma(input logic [9:0] s);
      return (s == 10'b0011111001) || (s == 10'b1100000110);
   endfunction

   task automatic chk(input string tag);
      n_run += 2;
      if (marker !== (m_cnt != 0)) begin
         n_fail++;
         $display("FAIL %s marker act=%b exp=%b t=%0t", tag, marker, (m_cnt != 0), $time);
      end
      if (seen !== m_seen) begin
         n_fail++;
         $display("FAIL %s seen act=%b exp=%b t=%0t", tag, seen, m_seen, $time);
      end
   endtask

   // check outputs, then drive one symbol and advance the model by one edge
   task automatic cyc(input string tag, input logic [9:0] s, input bit v,
                      input bit a, input int l);
      bit arm_evt, hit;
      @(negedge clk);
      chk(tag);
      sym = s; vld = v; aln = a; len = LEN_W'(l);
      arm_evt = a && !m_alq;
      hit = m_arm && a && v && is_comma(s) && !arm_evt;
      if (arm_evt) begin m_arm = 1; m_seen = 0; end
      else if (hit) begin m_arm = 0; m_seen = 1; end
      else if (!a) m_arm = 0;
      if (hit) m_cnt = (l == 0) ? 1 : l;
      else if (m_cnt > 0) m_cnt--;
      m_alq = a;
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [9:0] r;
      void'($urandom(32'h5eed_0281));
      m_alq = 0; m_arm = 0; m_seen = 0; m_cnt = 0;
      repeat (3) @(negedge clk);
      chk("R1 reset");
      rst_n = 1'b1;
      chk("R1 reset");
      // commas before arming are ignored
      cyc("R5 pre-arm", 10'b0011111001, 1, 0, 3);
      cyc("R5 pre-arm", 10'b1100000110, 1, 0, 3);
      cyc("R5 pre-arm", 10'h000, 0, 0, 3);
      // comma on the arming edge itself is ignored
      cyc("R5 arm edge", 10'b0011111001, 1, 1, 3);
      // near-miss symbols never match
      for (int b = 0; b < 10; b++) cyc("R4 near miss", 10'b0011111001 ^ (10'd1 << b), 1, 1, 3);
      for (int b = 0; b < 10; b++) cyc("R4 near miss", 10'b1100000110 ^ (10'd1 << b), 1, 1, 3);
      // valid low masks a comma
      cyc("R4 vld low", 10'b0011111001, 0, 1, 3);
      // negative form, pulse of 3
      cyc("R2 neg form", 10'b0011111001, 1, 1, 3);
      cyc("R7 width", 10'h155, 1, 1, 7);
      cyc("R6 second", 10'b1100000110, 1, 1, 7);
      for (int i = 0; i < 4; i++) cyc("R7 R8 tail", 10'h0aa, 1, 1, 7);
      // drop alignment: seen stays
      cyc("R8 sticky", 10'h000, 1, 0, 2);
      cyc("R8 sticky", 10'b0011111001, 1, 0, 2);
      // re-arm clears seen, positive form, length 0 -> one cycle
      cyc("R8 re-arm", 10'h000, 1, 1, 0);
      cyc("R3 pos form", 10'b1100000110, 1, 1, 0);
      cyc("R7 len0", 10'h000, 1, 1, 0);
      cyc("R7 len0", 10'h000, 1, 1, 0);
      // disarm without detection, then comma ignored
      cyc("R5 disarm", 10'h000, 1, 0, 4);
      cyc("R5 rearm", 10'h000, 1, 1, 4);
      cyc("R5 disarm", 10'h000, 1, 0, 4);
      cyc("R5 disarmed", 10'b0011111001, 1, 0, 4);
      cyc("R5 disarmed", 10'h000, 1, 0, 4);
      // maximum width
      cyc("R5 rearm", 10'h000, 1, 1, 15);
      cyc("R2 max width", 10'b0011111001, 1, 1, 15);
      for (int i = 0; i < 16; i++) cyc("R7 max width", 10'h3ff, 1, 1, 15);
      // random phase
      for (int i = 0; i < 4000; i++) begin
         r = 10'($urandom);
         if (($urandom % 12) == 0) r = (($urandom % 2) == 0) ? 10'b0011111001 : 10'b1100000110;
         cyc("R2 R3 R4 R5 R6 R7 R8 random", r, ($urandom % 4) != 0,
             (($urandom % 40) == 0) ? ~aln : aln, int'($urandom % 16));
      end
      @(negedge clk);
      chk("R7 R8 final");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule